// File: doc/BRIEF.md
# Display interrupt status aggregator

This block collects the interrupt events of a display controller that has one base channel (channel 0) and up to six auxiliary channels. Each channel reports start-of-frame, end-of-frame, branch-taken and input-underrun pulses, and any channel can raise a bus error. The controller itself adds disable-done, AC-bias-count, output-underrun, read-status and command pulses. A quick-disable event comes from the block's own control register. Every pulse sets a sticky status bit. The status bits are gated by per-source mask bits and combined into one level-sensitive interrupt line.

When an unmasked frame event or a bus error arrives while the interrupt line is low, the frame ID of the channel that caused it is loaded into an ID register. If the line is already high, the ID register is left alone and a sticky second-interrupt flag is set instead. Software reads and clears all state through a small word-wide register port. Writes take effect on the next clock edge. Reads are combinational.

Top module: `disp_irq_agg`

## Requirements
- R1: After reset, every readable register returns zero and `irq` is low.
- R2: Register map: address 0 is control, address 1 is the auxiliary mask, address 2 is status A, address 3 is status B, address 4 is the frame ID, and every other address reads zero. Control holds bits [9:0]: bit 0 is enable; bits 1 to 9 mask, in order, disable-done, SOF0, input-underrun0, output-underrun, quick-disable, EOF0, branch0, read-status and command. A write to the auxiliary mask keeps only the bits selected by 0x3F3F3F3F.
- R3: Status A bit positions: 0 disable-done, 1 SOF ch0, 2 bus error, 3 AC-bias count, 4 input-underrun ch0, 5 input-underrun ch1, 6 output underrun, 7 quick-disable, 8 EOF ch0, 9 branch ch0, 10 second-interrupt, 11 read-status, 12 command. Each bit is set one clock after its event and stays set until it is cleared.
- R4: For auxiliary channel n (1 to 6), status B uses bit n-1 for SOF, bit n+7 for EOF and bit n+15 for branch. For n of 2 or more, bit n+23 is input underrun. The auxiliary mask uses the same positions, and bit 24 of that mask masks the ch1 underrun bit in status A.
- R5: `irq` is high exactly when some status A source that has a mask (all bits except 2, 3 and 10) is set with its mask bit clear, or some status B bit is set with its auxiliary mask bit clear.
- R6: A SOF, EOF or branch event is a capture source when its mask bit is clear. If any capture source arrives while `irq` is low, the ID register loads the frame ID of the lowest-numbered channel that has one.
- R7: A capture source that arrives while `irq` is high leaves the ID register unchanged and sets status A bit 10.
- R8: A bus error sets status A bit 2 and writes its channel number into bits [30:28]. It is a capture source for its channel whatever the masks are.
- R9: Writing status A clears each of bits [11:0] where the written bit is 1; bit 12 cannot be cleared. Writing 1 to bit 2 also clears the channel field.
- R10: Writing status B clears only the bits selected by 0x003E3F3F where the written bit is 1.
- R11: Writing control with bit 0 at 0 while enable is set sets status A bit 7.
- R12: When a status bit is set and cleared in the same cycle, it ends up set, and a bus error in that cycle loads its channel number into the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_sof | input | NCH | Start-of-frame pulse per channel |
| ev_eof | input | NCH | End-of-frame pulse per channel |
| ev_brn | input | NCH | Branch-taken pulse per channel |
| ev_und | input | NCH | Input-underrun pulse per channel |
| ev_berr | input | 1 | Bus-error pulse |
| berr_ch | input | 3 | Channel of the bus error (below NCH) |
| fid_flat | input | NCH*IDW | Current frame ID of each channel, channel 0 lowest |
| ev_dis_done | input | 1 | Disable-done pulse |
| ev_acb | input | 1 | AC-bias count pulse |
| ev_out_und | input | 1 | Output-underrun pulse |
| ev_rdst | input | 1 | Read-status pulse |
| ev_cmd | input | 1 | Command pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Combined interrupt level |

## Verification
The hardest state to reach is the one where several things meet in one cycle. These are: capture sources on different channels arriving while the line is low; a capture arriving while the line is already high; and an event landing in the same cycle as a write-one-to-clear of its own bit. Directed sequences build each of these on purpose. The quick-disable write is issued while enable is set, and status B bits that cannot be cleared are made sticky before a clear-all write. A long pseudo-random phase then mixes sparse event pulses with random register writes. After every clock, it compares every register and the interrupt line against an arithmetic model of the requirements.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int DW  = 32;
  localparam int S0W = 13;
  localparam int CW  = 10;

  // status A positions
  localparam int S0_DONE = 0;
  localparam int S0_SOF0 = 1;
  localparam int S0_BER  = 2;
  localparam int S0_ACB  = 3;
  localparam int S0_UND0 = 4;
  localparam int S0_UND1 = 5;
  localparam int S0_OUND = 6;
  localparam int S0_QD   = 7;
  localparam int S0_EOF0 = 8;
  localparam int S0_BRN0 = 9;
  localparam int S0_SINT = 10;
  localparam int S0_RDST = 11;
  localparam int S0_CMD  = 12;
  localparam int BCH_LSB = 28;

  // control positions
  localparam int C_EN    = 0;
  localparam int C_MDONE = 1;
  localparam int C_MSOF0 = 2;
  localparam int C_MUND0 = 3;
  localparam int C_MOUND = 4;
  localparam int C_MQD   = 5;
  localparam int C_MEOF0 = 6;
  localparam int C_MBRN0 = 7;
  localparam int C_MRDST = 8;
  localparam int C_MCMD  = 9;

  // auxiliary mask bit that masks ch1 underrun in status A
  localparam int M_UND1  = 24;

  localparam logic [S0W-1:0] S0_CLR_MASK = 13'h0FFF;
  localparam logic [DW-1:0]  S1_CLR_MASK = 32'h003E_3F3F;
  localparam logic [DW-1:0]  MASK_KEEP   = 32'h3F3F_3F3F;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_MASK  = 3'd1,
    A_STATA = 3'd2,
    A_STATB = 3'd3,
    A_FID   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/dia_rst_sync.sv
module dia_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/dia_ctrl_regs.sv
module dia_ctrl_regs
  import disp_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] ctrl_q,
  output logic [DW-1:0] mask_q,
  output logic          qd_set
);
  logic [CW-1:0] ctrl_d;
  logic [DW-1:0] mask_d;

  always_comb begin
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    if (wr_ctrl) ctrl_d = wdata[CW-1:0];
    if (wr_mask) mask_d = wdata & MASK_KEEP;
    qd_set = wr_ctrl & ctrl_q[C_EN] & ~wdata[C_EN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_mask) mask_q <= mask_d;
    end
  end

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q & ~MASK_KEEP) == '0);
endmodule

// File: rtl/dia_capture.sv
module dia_capture #(
  parameter int NCH = 7,
  parameter int IDW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     cap_i,
  input  logic [NCH*IDW-1:0] fid_flat,
  input  logic               irq_i,
  output logic [IDW-1:0]     fid_q,
  output logic               sint_set
);
  logic [IDW-1:0] sel_fid;
  logic           any_cap;
  logic           load_en;

  always_comb begin
    sel_fid = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (cap_i[c]) sel_fid = fid_flat[c*IDW +: IDW];
    end
    any_cap  = |cap_i;
    load_en  = any_cap & ~irq_i;
    sint_set = any_cap & irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fid_q <= '0;
    else if (load_en) fid_q <= sel_fid;
  end

  // R7
  fid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cap && irq_i) |=> $stable(fid_q));

  // R6
  fid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i == '0) |=> $stable(fid_q));
endmodule

// File: rtl/dia_status.sv
module dia_status
  import disp_irq_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev_sof,
  input  logic [NCH-1:0] ev_eof,
  input  logic [NCH-1:0] ev_brn,
  input  logic [NCH-1:0] ev_und,
  input  logic           ev_berr,
  input  logic [2:0]     berr_ch,
  input  logic           ev_dis_done,
  input  logic           ev_acb,
  input  logic           ev_out_und,
  input  logic           ev_rdst,
  input  logic           ev_cmd,
  input  logic           qd_set,
  input  logic           sint_set,
  input  logic [S0W-1:0] clr_a,
  input  logic [DW-1:0]  clr_b,
  output logic [S0W-1:0] sta_q,
  output logic [2:0]     bch_q,
  output logic [DW-1:0]  stb_q
);
  logic [S0W-1:0] set_a, sta_d;
  logic [DW-1:0]  set_b, stb_d;
  logic [2:0]     bch_d;

  always_comb begin
    set_a          = '0;
    set_a[S0_DONE] = ev_dis_done;
    set_a[S0_SOF0] = ev_sof[0];
    set_a[S0_BER]  = ev_berr;
    set_a[S0_ACB]  = ev_acb;
    set_a[S0_UND0] = ev_und[0];
    set_a[S0_UND1] = ev_und[1];
    set_a[S0_OUND] = ev_out_und;
    set_a[S0_QD]   = qd_set;
    set_a[S0_EOF0] = ev_eof[0];
    set_a[S0_BRN0] = ev_brn[0];
    set_a[S0_SINT] = sint_set;
    set_a[S0_RDST] = ev_rdst;
    set_a[S0_CMD]  = ev_cmd;

    set_b = '0;
    for (int n = 1; n < NCH; n++) begin
      set_b[n-1]  = ev_sof[n];
      set_b[n+7]  = ev_eof[n];
      set_b[n+15] = ev_brn[n];
      if (n >= 2) set_b[n+23] = ev_und[n];
    end

    sta_d = (sta_q & ~clr_a) | set_a;
    stb_d = (stb_q & ~clr_b) | set_b;

    bch_d = bch_q;
    if (ev_berr)            bch_d = berr_ch;
    else if (clr_a[S0_BER]) bch_d = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q <= '0;
      stb_q <= '0;
      bch_q <= '0;
    end else begin
      sta_q <= sta_d;
      stb_q <= stb_d;
      bch_q <= bch_d;
    end
  end

  // R3
  sta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a == '0) |=> ((sta_q & $past(sta_q)) == $past(sta_q)));

  // R8
  berr_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_berr |=> (sta_q[S0_BER] && bch_q == $past(berr_ch)));

  // R10
  stb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stb_q & ~S1_CLR_MASK & $past(stb_q)) == ($past(stb_q) & ~S1_CLR_MASK)));

  // R8
  berr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_berr |-> (int'(berr_ch) < NCH));
endmodule

// File: rtl/disp_irq_agg.sv
module disp_irq_agg
  import disp_irq_pkg::*;
#(
  parameter int NCH = 7,
  parameter int IDW = 8
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NCH-1:0]     ev_sof,
  input  logic [NCH-1:0]     ev_eof,
  input  logic [NCH-1:0]     ev_brn,
  input  logic [NCH-1:0]     ev_und,
  input  logic               ev_berr,
  input  logic [2:0]         berr_ch,
  input  logic [NCH*IDW-1:0] fid_flat,
  input  logic               ev_dis_done,
  input  logic               ev_acb,
  input  logic               ev_out_und,
  input  logic               ev_rdst,
  input  logic               ev_cmd,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq
);
  localparam int PADW = DW - IDW;

  logic           rst_n;
  logic [CW-1:0]  ctrl_q;
  logic [DW-1:0]  mask_q;
  logic           qd_set, sint_set;
  logic [S0W-1:0] sta_q, clr_a, hit_a;
  logic [DW-1:0]  stb_q, clr_b;
  logic [2:0]     bch_q;
  logic [IDW-1:0] fid_q;
  logic [NCH-1:0] m_sof, m_eof, m_brn, cap;
  logic           wr_ctrl, wr_mask, wr_sta, wr_stb;

  dia_rst_sync u_rst (.clk(clk), .rst_ni(rst_ni), .rst_no(rst_n));

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    wr_mask = reg_wr && (reg_addr == A_MASK);
    wr_sta  = reg_wr && (reg_addr == A_STATA);
    wr_stb  = reg_wr && (reg_addr == A_STATB);
    clr_a   = wr_sta ? (reg_wdata[S0W-1:0] & S0_CLR_MASK) : '0;
    clr_b   = wr_stb ? (reg_wdata & S1_CLR_MASK) : '0;
  end

  dia_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
    .wdata(reg_wdata), .ctrl_q(ctrl_q), .mask_q(mask_q), .qd_set(qd_set)
  );

  // per-channel masks for the capture path
  always_comb begin
    m_sof[0] = ctrl_q[C_MSOF0];
    m_eof[0] = ctrl_q[C_MEOF0];
    m_brn[0] = ctrl_q[C_MBRN0];
    for (int n = 1; n < NCH; n++) begin
      m_sof[n] = mask_q[n-1];
      m_eof[n] = mask_q[n+7];
      m_brn[n] = mask_q[n+15];
    end
    for (int c = 0; c < NCH; c++) begin
      cap[c] = (ev_sof[c] & ~m_sof[c]) | (ev_eof[c] & ~m_eof[c]) |
               (ev_brn[c] & ~m_brn[c]) | (ev_berr && (int'(berr_ch) == c));
    end
  end

  dia_capture #(.NCH(NCH), .IDW(IDW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .fid_flat(fid_flat),
    .irq_i(irq), .fid_q(fid_q), .sint_set(sint_set)
  );

  dia_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_eof(ev_eof),
    .ev_brn(ev_brn), .ev_und(ev_und), .ev_berr(ev_berr), .berr_ch(berr_ch),
    .ev_dis_done(ev_dis_done), .ev_acb(ev_acb), .ev_out_und(ev_out_und),
    .ev_rdst(ev_rdst), .ev_cmd(ev_cmd), .qd_set(qd_set), .sint_set(sint_set),
    .clr_a(clr_a), .clr_b(clr_b), .sta_q(sta_q), .bch_q(bch_q), .stb_q(stb_q)
  );

  // interrupt level
  always_comb begin
    hit_a          = '0;
    hit_a[S0_DONE] = sta_q[S0_DONE] & ~ctrl_q[C_MDONE];
    hit_a[S0_SOF0] = sta_q[S0_SOF0] & ~ctrl_q[C_MSOF0];
    hit_a[S0_UND0] = sta_q[S0_UND0] & ~ctrl_q[C_MUND0];
    hit_a[S0_UND1] = sta_q[S0_UND1] & ~mask_q[M_UND1];
    hit_a[S0_OUND] = sta_q[S0_OUND] & ~ctrl_q[C_MOUND];
    hit_a[S0_QD]   = sta_q[S0_QD]   & ~ctrl_q[C_MQD];
    hit_a[S0_EOF0] = sta_q[S0_EOF0] & ~ctrl_q[C_MEOF0];
    hit_a[S0_BRN0] = sta_q[S0_BRN0] & ~ctrl_q[C_MBRN0];
    hit_a[S0_RDST] = sta_q[S0_RDST] & ~ctrl_q[C_MRDST];
    hit_a[S0_CMD]  = sta_q[S0_CMD]  & ~ctrl_q[C_MCMD];
    irq = (|hit_a) | (|(stb_q & ~mask_q));
  end

  // read path
  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {{(DW-CW){1'b0}}, ctrl_q};
      A_MASK:  reg_rdata = mask_q;
      A_STATA: reg_rdata = {1'b0, bch_q, {(BCH_LSB-S0W){1'b0}}, sta_q};
      A_STATB: reg_rdata = stb_q;
      A_FID:   reg_rdata = {{PADW{1'b0}}, fid_q};
      default: reg_rdata = '0;
    endcase
  end

  // R11
  qd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q[C_EN] && !reg_wdata[C_EN]) |=> sta_q[S0_QD]);

  // R7
  sint_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cap) && irq) |=> sta_q[S0_SINT]);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_q == '0 && stb_q == '0) |-> !irq);
endmodule

// File: tb/disp_irq_agg_bench.sv
`timescale 1ns/1ps
module disp_irq_agg_bench;
  logic clk = 1'b0;
  logic rst_ni;
  logic [6:0] sof, eof, brn, und;
  logic berr;
  logic [2:0] bch;
  logic dis, acb, oun, rdst, cmd;
  logic wr;
  logic [2:0] addr;
  logic [31:0] wdata, rdata;
  logic [6:0][7:0] fid;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] xs = 32'h1234_5678;

  logic [9:0]  m_ctrl;
  logic [31:0] m_mask, m_s1;
  logic [12:0] m_s0;
  logic [2:0]  m_bch;
  logic [7:0]  m_fid;

  always #2.5 clk = ~clk;

  disp_irq_agg #(.NCH(7), .IDW(8)) u_disp_irq_agg (
    .clk(clk), .rst_ni(rst_ni), .ev_sof(sof), .ev_eof(eof), .ev_brn(brn),
    .ev_und(und), .ev_berr(berr), .berr_ch(bch), .fid_flat(fid),
    .ev_dis_done(dis), .ev_acb(acb), .ev_out_und(oun), .ev_rdst(rdst),
    .ev_cmd(cmd), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] rnd();
    xs = xs ^ (xs << 13);
    xs = xs ^ (xs >> 17);
    xs = xs ^ (xs << 5);
    return xs;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #0.2;
    v = rdata;
  endtask

  function automatic logic model_irq();
    logic [9:0] h;
    h = {m_s0[0] & !m_ctrl[1], m_s0[1] & !m_ctrl[2], m_s0[4] & !m_ctrl[3],
         m_s0[5] & !m_mask[24], m_s0[6] & !m_ctrl[4], m_s0[7] & !m_ctrl[5],
         m_s0[8] & !m_ctrl[6], m_s0[9] & !m_ctrl[7], m_s0[11] & !m_ctrl[8],
         m_s0[12] & !m_ctrl[9]};
    return (|h) | (|(m_s1 & ~m_mask));
  endfunction

  task automatic clear_inputs();
    sof = '0; eof = '0; brn = '0; und = '0; berr = 0; bch = '0;
    dis = 0; acb = 0; oun = 0; rdst = 0; cmd = 0; wr = 0; addr = '0; wdata = '0;
  endtask

  task automatic check_all();
    logic [31:0] v;
    checks++;
    if (irq !== model_irq()) begin
      fails++;
      $display("FAIL R5: irq actual %b expected %b at %0t", irq, model_irq(), $time);
    end
    rd(3'd0, v); check("R2 control", v, {22'd0, m_ctrl});
    rd(3'd1, v); check("R2 aux mask", v, m_mask);
    rd(3'd2, v); check("R3 status A", v, {1'b0, m_bch, 15'd0, m_s0});
    rd(3'd3, v); check("R4 status B", v, m_s1);
    rd(3'd4, v); check("R6 frame ID", v, {24'd0, m_fid});
  endtask

  // one clock: model next state from the requirements, then compare
  task automatic tick();
    logic [6:0] cap;
    int first;
    logic [12:0] set0, clr0, n_s0;
    logic [31:0] set1, clr1, n_s1, n_mask;
    logic [9:0] n_ctrl;
    logic [2:0] n_bch;
    logic [7:0] n_fid;
    logic il;
    il = model_irq();
    for (int c = 0; c < 7; c++) begin
      logic us, ue, ub;
      us = (c == 0) ? !m_ctrl[2] : !m_mask[c-1];
      ue = (c == 0) ? !m_ctrl[6] : !m_mask[c+7];
      ub = (c == 0) ? !m_ctrl[7] : !m_mask[c+15];
      cap[c] = (sof[c] & us) | (eof[c] & ue) | (brn[c] & ub) | (berr && bch == c);
    end
    first = 0;
    for (int c = 6; c >= 0; c--) if (cap[c]) first = c;
    set0 = {cmd, rdst, (|cap) & il, brn[0], eof[0],
            wr && addr == 3'd0 && m_ctrl[0] && !wdata[0],
            oun, und[1], und[0], acb, berr, sof[0], dis};
    set1 = '0;
    for (int n = 1; n < 7; n++) begin
      set1[n-1] = sof[n]; set1[n+7] = eof[n]; set1[n+15] = brn[n];
      if (n >= 2) set1[n+23] = und[n];
    end
    clr0 = (wr && addr == 3'd2) ? (wdata[12:0] & 13'h0FFF) : 13'd0;
    clr1 = (wr && addr == 3'd3) ? (wdata & 32'h003E3F3F) : 32'd0;
    n_s0 = (m_s0 & ~clr0) | set0;
    n_s1 = (m_s1 & ~clr1) | set1;
    n_bch = berr ? bch : (clr0[2] ? 3'd0 : m_bch);
    n_fid = ((|cap) && !il) ? fid[first] : m_fid;
    n_ctrl = (wr && addr == 3'd0) ? wdata[9:0] : m_ctrl;
    n_mask = (wr && addr == 3'd1) ? (wdata & 32'h3F3F3F3F) : m_mask;
    @(posedge clk);
    @(negedge clk);
    m_s0 = n_s0; m_s1 = n_s1; m_bch = n_bch; m_fid = n_fid;
    m_ctrl = n_ctrl; m_mask = n_mask;
    clear_inputs();
    check_all();
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1; tick();
  endtask

  task automatic do_reset();
    rst_ni = 0;
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    m_ctrl = '0; m_mask = '0; m_s0 = '0; m_s1 = '0; m_bch = '0; m_fid = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 7; c++) fid[c] = 8'h10 * (c + 1) + 8'(c);
    do_reset();

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reset read", v, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    // R2 register masking
    wreg(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R2 control width", v, 32'h3FF);
    wreg(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R2 mask keep", v, 32'h3F3F3F3F);
    rd(3'd5, v); check("R2 unused address", v, 32'd0);

    // R6 priority, R7 second interrupt, R11 quick disable
    do_reset();
    wreg(3'd0, 32'h1);
    fid[1] = 8'h11; fid[5] = 8'h55; fid[3] = 8'h33;
    sof[5] = 1; eof[1] = 1; tick();
    rd(3'd4, v); check("R6 lowest channel ID", v, 32'h11);
    check("R5 irq after unmasked event", {31'd0, irq}, 32'd1);
    brn[3] = 1; tick();
    rd(3'd4, v); check("R7 ID held", v, 32'h11);
    rd(3'd2, v); check("R7 second-interrupt bit", v & 32'h400, 32'h400);
    wreg(3'd0, 32'h0);
    rd(3'd2, v); check("R11 quick-disable bit", v & 32'h80, 32'h80);

    // R9 status A clear limits
    cmd = 1; tick();
    wreg(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R9 command bit survives", v, 32'h1000);

    // R10 status B clear limits
    wreg(3'd3, 32'hFFFF_FFFF);
    brn[1] = 1; und[3] = 1; tick();
    wreg(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R10 unclearable bits", v, 32'h0401_0000);

    // R8 bus error ignores masks
    do_reset();
    wreg(3'd0, 32'h3FE);
    wreg(3'd1, 32'hFFFF_FFFF);
    fid[4] = 8'h44; berr = 1; bch = 3'd4; tick();
    rd(3'd4, v); check("R8 bus error ID", v, 32'h44);
    rd(3'd2, v); check("R8 bus error field", v, 32'h4000_0004);
    check("R5 bus error not in irq", {31'd0, irq}, 32'd0);
    wreg(3'd2, 32'h4);
    rd(3'd2, v); check("R9 field cleared", v, 32'd0);

    // R12 set beats clear
    eof[0] = 1; berr = 1; bch = 3'd6;
    addr = 3'd2; wdata = 32'h104; wr = 1; tick();
    rd(3'd2, v); check("R12 set wins", v, 32'h6000_0104);

    // R3/R4 sweep over every channel and event kind
    do_reset();
    wreg(3'd0, 32'h1);
    for (int c = 0; c < 7; c++) begin
      for (int k = 0; k < 4; k++) begin
        int pos;
        case (k)
          0: sof[c] = 1;
          1: eof[c] = 1;
          2: brn[c] = 1;
          default: und[c] = 1;
        endcase
        tick();
        if (c == 0) begin
          pos = (k == 0) ? 1 : (k == 1) ? 8 : (k == 2) ? 9 : 4;
          rd(3'd2, v); check("R3 ch0 bit", (v >> pos) & 1, 32'd1);
        end else if (k == 3 && c == 1) begin
          rd(3'd2, v); check("R4 ch1 underrun in status A", (v >> 5) & 1, 32'd1);
        end else begin
          pos = (k == 0) ? c - 1 : (k == 1) ? c + 7 : (k == 2) ? c + 15 : c + 23;
          rd(3'd3, v); check("R4 aux bit", (v >> pos) & 1, 32'd1);
        end
        wreg(3'd2, 32'hFFFF_FFFF);
        wreg(3'd3, 32'hFFFF_FFFF);
      end
    end

    // pseudo-random mix
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      sof = 7'(rnd() & rnd() & rnd());
      eof = 7'(rnd() & rnd() & rnd());
      brn = 7'(rnd() & rnd() & rnd());
      und = 7'(rnd() & rnd() & rnd() & rnd());
      berr = ((rnd() & 32'hF) == 0);
      bch = 3'(rnd() % 7);
      dis = ((rnd() & 32'h1F) == 0);
      acb = ((rnd() & 32'h1F) == 0);
      oun = ((rnd() & 32'h1F) == 0);
      rdst = ((rnd() & 32'h1F) == 0);
      cmd = ((rnd() & 32'h3F) == 0);
      for (int c = 0; c < 7; c++) fid[c] = 8'(rnd());
      if ((rnd() & 32'h3) == 0) begin
        wr = 1; addr = 3'(rnd() % 4);
        wdata = rnd() | ((rnd() & 32'h1) ? 32'hFFFF_FFFF : 32'd0);
      end
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule